// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block carries out a single Enhanced Parallel Port transfer each time the host side presents a request. A request is either a write or a read, and it targets either the peripheral's address register or its data register. The engine drives the direction line, one of two strobes and the data bus. It then follows the peripheral's WAIT handshake through to the end of the transfer and reports completion with a one-cycle `done_o` pulse. On a read, the byte the peripheral returned is presented with that pulse.

A peripheral that never answers would leave the host waiting for ever. To prevent this, a timer bounds every transfer. The timer limit is derived from the clock frequency and a timeout in nanoseconds, and the default is 10 µs. When the limit is reached, the transfer is abandoned, `done_o` still pulses, and a sticky timeout flag is raised. The host clears that flag explicitly.

The engine, including its timer, only operates while the port mode field holds the EPP code 3'b100. In every other mode the timer is held and requests are ignored.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, `done_o` and `pd_oe_o` are 0, and `write_n_o`, `dstb_n_o`, `astb_n_o` are 1. `timeout_o` is 0.
- R2: `req_valid_i` starts a transfer only while the engine is idle and `mode_i` equals 3'b100. In any other mode a request produces no strobe and no `done_o`, and it leaves `timeout_o` unchanged.
- R3: During a write transfer (`req_write_i`=1), `write_n_o` is 0 and `pd_oe_o` is 1 with `pd_o` equal to the request byte, for the whole time a strobe is active. During a read transfer, `write_n_o` is 1 and `pd_oe_o` is 0.
- R4: A data-register request (`req_addr_i`=0) pulses only `dstb_n_o` low. An address-register request (`req_addr_i`=1) pulses only `astb_n_o` low. The two strobes are never low together.
- R5: A strobe is not driven low while the synchronised `wait_i` is high.
- R6: Once `wait_i` rises, the strobe is released. After `wait_i` then falls, `done_o` pulses high for exactly one cycle.
- R7: On a read, `pd_i` is captured while `wait_i` is high and the strobe is still active, and it appears on `rdata_o` when `done_o` pulses.
- R8: If a transfer is still running after TIMEOUT_CYCLES = CLK_FREQ_MHZ*TIMEOUT_NS/1000 cycles, it is aborted. The abort releases the strobes, pulses `done_o` and sets `timeout_o`. An aborted read returns 8'hFF on `rdata_o`.
- R9: `timeout_o` stays set across later successful transfers. It clears in the cycle after `clr_timeout_i` is asserted.
- R10: If `mode_i` leaves 3'b100 during a transfer, the strobes return high on the next cycle and no `done_o` is produced for that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Port mode field; 3'b100 enables the engine |
| req_valid_i | input | 1 | One-cycle transfer request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 1 | 1 = address register, 0 = data register |
| req_wdata_i | input | PD_W | Byte to write |
| clr_timeout_i | input | 1 | Clears the timeout flag |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | PD_W | Byte read from the peripheral (8'hFF on abort) |
| timeout_o | output | 1 | Sticky timeout flag |
| write_n_o | output | 1 | Direction line, low for writes |
| dstb_n_o | output | 1 | Data strobe, active low |
| astb_n_o | output | 1 | Address strobe, active low |
| pd_o | output | PD_W | Data bus output value |
| pd_oe_o | output | 1 | Data bus output enable |
| pd_i | input | PD_W | Data bus input value |
| wait_i | input | 1 | Peripheral WAIT handshake, asynchronous |

## Verification
The properties assume the host pulses `req_valid_i` only while no transfer is outstanding. They also assume `pd_i` is stable while `wait_i` is high. The bench keeps to both: it waits for `done_o` before issuing the next request, and its peripheral model loads `pd_i` before raising `wait_i`. The model answers a strobe after a programmed delay. That delay is swept over short values, which finish well inside the shortened limit, and over long values, which clearly exceed it. This keeps every expected outcome away from the exact timer boundary.

// File: rtl/epp_pkg.sv
package epp_pkg;
    parameter int PD_W = 8;
    localparam logic [2:0] EPP_MODE = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_FINISH
    } epp_state_e;

    typedef struct packed {
        epp_state_e      state;
        logic            is_write;
        logic            is_addr;
        logic [PD_W-1:0] wdata;
        logic [PD_W-1:0] rdata;
        logic            done;
        logic            tout;
    } epp_regs_t;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = async_i;
        end else begin : g_multi
            assign chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = RELOAD;
        else if (run_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int CLK_FREQ_MHZ = 250,
    parameter int TIMEOUT_NS   = 10000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode_i,
    input  logic            req_valid_i,
    input  logic            req_write_i,
    input  logic            req_addr_i,
    input  logic [PD_W-1:0] req_wdata_i,
    input  logic            clr_timeout_i,
    output logic            done_o,
    output logic [PD_W-1:0] rdata_o,
    output logic            timeout_o,
    output logic            write_n_o,
    output logic            dstb_n_o,
    output logic            astb_n_o,
    output logic [PD_W-1:0] pd_o,
    output logic            pd_oe_o,
    input  logic [PD_W-1:0] pd_i,
    input  logic            wait_i
);
    localparam int TIMEOUT_CYCLES = CLK_FREQ_MHZ * TIMEOUT_NS / 1000;

    epp_regs_t r_d, r_q;
    logic      wait_s;
    logic      epp_on;
    logic      busy;
    logic      accept;
    logic      expired;

    epp_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wait_i),
        .sync_o  (wait_s)
    );

    assign epp_on = (mode_i == EPP_MODE);
    assign busy   = (r_q.state == ST_SETUP) || (r_q.state == ST_STROBE) ||
                    (r_q.state == ST_RELEASE);
    assign accept = (r_q.state == ST_IDLE) && req_valid_i && epp_on;

    epp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .run_i     (busy && epp_on),
        .expired_o (expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (clr_timeout_i) r_d.tout = 1'b0;

        if (busy && !epp_on) begin
            r_d.state = ST_IDLE;
        end else if (busy && expired) begin
            r_d.state = ST_FINISH;
            r_d.done  = 1'b1;
            r_d.tout  = 1'b1;
            if (!r_q.is_write) r_d.rdata = '1;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (accept) begin
                        r_d.state    = ST_SETUP;
                        r_d.is_write = req_write_i;
                        r_d.is_addr  = req_addr_i;
                        r_d.wdata    = req_wdata_i;
                    end
                end
                ST_SETUP: begin
                    if (!wait_s) r_d.state = ST_STROBE;
                end
                ST_STROBE: begin
                    if (wait_s) begin
                        r_d.state = ST_RELEASE;
                        if (!r_q.is_write) r_d.rdata = pd_i;
                    end
                end
                ST_RELEASE: begin
                    if (!wait_s) begin
                        r_d.state = ST_FINISH;
                        r_d.done  = 1'b1;
                    end
                end
                ST_FINISH: begin
                    r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.is_write <= 1'b0;
            r_q.is_addr  <= 1'b0;
            r_q.wdata    <= '0;
            r_q.rdata    <= '0;
            r_q.done     <= 1'b0;
            r_q.tout     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = r_q.done;
    assign rdata_o   = r_q.rdata;
    assign timeout_o = r_q.tout;
    assign write_n_o = !(busy && r_q.is_write);
    assign pd_oe_o   = busy && r_q.is_write;
    assign pd_o      = r_q.wdata;
    assign dstb_n_o  = !((r_q.state == ST_STROBE) && !r_q.is_addr);
    assign astb_n_o  = !((r_q.state == ST_STROBE) && r_q.is_addr);
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       clr_timeout_i,
    input logic       done_o,
    input logic       timeout_o,
    input logic       write_n_o,
    input logic       dstb_n_o,
    input logic       astb_n_o,
    input logic       pd_oe_o
);
    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dstb_n_o || astb_n_o);

    // R3
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dstb_n_o && astb_n_o) && pd_oe_o) |-> !write_n_o);

    // R3
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dstb_n_o && astb_n_o) && !pd_oe_o) |-> write_n_o);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 3'b100) |=> (dstb_n_o && astb_n_o));

    // R8
    tout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> done_o);

    // R9
    tout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_timeout_i |=> (!timeout_o || done_o));
endmodule

bind epp_cycle_engine epp_cycle_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .clr_timeout_i (clr_timeout_i),
    .done_o        (done_o),
    .timeout_o     (timeout_o),
    .write_n_o     (write_n_o),
    .dstb_n_o      (dstb_n_o),
    .astb_n_o      (astb_n_o),
    .pd_oe_o       (pd_oe_o)
);

// File: tb/epp_cycle_engine_tb_top.sv
module epp_cycle_engine_tb_top;
    localparam int LIMIT = 25;  // 250 MHz * 100 ns

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'b100;
    logic       req_valid_i = 1'b0;
    logic       req_write_i = 1'b0;
    logic       req_addr_i = 1'b0;
    logic [7:0] req_wdata_i = 8'h00;
    logic       clr_timeout_i = 1'b0;
    logic       done_o;
    logic [7:0] rdata_o;
    logic       timeout_o;
    logic       write_n_o;
    logic       dstb_n_o;
    logic       astb_n_o;
    logic [7:0] pd_o;
    logic       pd_oe_o;
    logic [7:0] pd_i = 8'h00;
    logic       wait_i = 1'b0;

    int errors = 0;
    int checks = 0;
    int periph_delay = 0;
    logic [7:0] periph_data = 8'h00;

    // monitor state
    logic exp_wr = 1'b0;
    logic exp_ad = 1'b0;
    logic [7:0] exp_wd = 8'h00;
    int   saw_dstb, saw_astb, dir_bad, bus_bad, done_cnt, strobe_waithigh;

    always #2 clk = ~clk;

    epp_cycle_engine #(.CLK_FREQ_MHZ(250), .TIMEOUT_NS(100), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_valid_i(req_valid_i),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .clr_timeout_i(clr_timeout_i), .done_o(done_o), .rdata_o(rdata_o),
        .timeout_o(timeout_o), .write_n_o(write_n_o), .dstb_n_o(dstb_n_o),
        .astb_n_o(astb_n_o), .pd_o(pd_o), .pd_oe_o(pd_oe_o), .pd_i(pd_i), .wait_i(wait_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        saw_dstb = 0; saw_astb = 0; dir_bad = 0; bus_bad = 0;
        done_cnt = 0; strobe_waithigh = 0;
    endtask

    always @(negedge clk) begin
        if (!dstb_n_o) saw_dstb++;
        if (!astb_n_o) saw_astb++;
        if (!dstb_n_o || !astb_n_o) begin
            if (wait_i && saw_dstb + saw_astb == 1) strobe_waithigh++;
            if (write_n_o != !exp_wr) dir_bad++;
            if (exp_wr && (!pd_oe_o || pd_o != exp_wd)) bus_bad++;
            if (!exp_wr && pd_oe_o) bus_bad++;
        end
        if (done_o) done_cnt++;
    end

    // peripheral model
    initial begin
        forever begin
            @(negedge clk);
            if (!dstb_n_o || !astb_n_o) begin
                for (int n = 0; n < periph_delay && (!dstb_n_o || !astb_n_o); n++)
                    @(negedge clk);
                if (!dstb_n_o || !astb_n_o) begin
                    pd_i   = periph_data;
                    wait_i = 1'b1;
                    while (!dstb_n_o || !astb_n_o) @(negedge clk);
                    for (int n = 0; n < periph_delay; n++) @(negedge clk);
                    wait_i = 1'b0;
                end
            end
        end
    end

    task automatic request(input logic wr, input logic ad, input logic [7:0] wd);
        exp_wr = wr; exp_ad = ad; exp_wd = wd;
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = wr; req_addr_i = ad; req_wdata_i = wd;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic wait_done(output bit got, output logic [7:0] rd, output logic tf);
        got = 0; rd = 8'h00; tf = 1'b0;
        for (int i = 0; i < 200 && !got; i++) begin
            if (done_o) begin
                got = 1; rd = rdata_o; tf = timeout_o;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic transfer(input logic wr, input logic ad, input logic [7:0] wd,
                            input logic [7:0] pdata, input int dly, input logic tf_before);
        bit got; logic [7:0] rd; logic tf; bit expect_to;
        periph_delay = dly; periph_data = pdata;
        clear_mon();
        request(wr, ad, wd);
        wait_done(got, rd, tf);
        expect_to = (dly > 10);
        chk(got, "R6 done pulse", got, 1);
        @(negedge clk);
        chk(!done_o, "R6 done one cycle", done_o, 0);
        chk(dir_bad == 0 && bus_bad == 0, "R3 direction/bus", dir_bad + bus_bad, 0);
        if (ad) chk(saw_astb > 0 && saw_dstb == 0, "R4 address strobe", saw_dstb, 0);
        else    chk(saw_dstb > 0 && saw_astb == 0, "R4 data strobe", saw_astb, 0);
        chk(tf == (expect_to | tf_before), "R8 timeout flag", tf, expect_to | tf_before);
        if (!wr) begin
            if (expect_to) chk(rd == 8'hFF, "R8 aborted read", rd, 8'hFF);
            else           chk(rd == pdata, "R7 read data", rd, pdata);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); clr_timeout_i = 1'b1;
        @(negedge clk); clr_timeout_i = 1'b0;
        chk(!timeout_o, "R9 clear", timeout_o, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit got; logic [7:0] rd; logic tf;
        clear_mon();
        repeat (3) @(negedge clk);
        chk(!done_o && !pd_oe_o && write_n_o && dstb_n_o && astb_n_o && !timeout_o,
            "R1 reset state", {done_o, pd_oe_o, write_n_o, dstb_n_o, astb_n_o, timeout_o}, 6'b001110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // sweep of short response delays, all four kinds
        for (int d = 0; d <= 5; d++)
            for (int k = 0; k < 4; k++)
                transfer(k[0], k[1], 8'(d * 37 + k * 11 + 5), 8'(d * 53 + k * 29 + 3), d, 1'b0);

        // long delays: aborts, flag sticky over a good transfer
        transfer(1'b0, 1'b0, 8'h00, 8'h5A, 40, 1'b0);
        transfer(1'b1, 1'b1, 8'hC3, 8'h00, 2, 1'b1);
        chk(timeout_o, "R9 sticky", timeout_o, 1);
        clear_flag();
        transfer(1'b1, 1'b0, 8'h81, 8'h00, 60, 1'b0);
        clear_flag();
        transfer(1'b0, 1'b1, 8'h00, 8'hE7, 40, 1'b0);
        clear_flag();

        // R5: WAIT held high, strobe never driven, cycle times out
        wait_i = 1'b1;
        clear_mon();
        request(1'b0, 1'b0, 8'h00);
        wait_done(got, rd, tf);
        chk(saw_dstb == 0 && saw_astb == 0, "R5 no strobe while wait high", saw_dstb + saw_astb, 0);
        chk(got && tf && rd == 8'hFF, "R8 timeout with wait high", rd, 8'hFF);
        wait_i = 1'b0;
        repeat (4) @(negedge clk);
        clear_flag();

        // R2: non-EPP mode ignores requests
        mode_i = 3'b001;
        clear_mon();
        request(1'b1, 1'b0, 8'h3C);
        repeat (2 * LIMIT) @(negedge clk);
        chk(done_cnt == 0 && saw_dstb == 0 && saw_astb == 0 && !timeout_o,
            "R2 request ignored", done_cnt + saw_dstb + saw_astb, 0);
        mode_i = 3'b100;
        repeat (2) @(negedge clk);

        // R10: mode leaves EPP mid-transfer
        periph_delay = 40;
        clear_mon();
        request(1'b0, 1'b0, 8'h00);
        repeat (4) @(negedge clk);
        chk(!dstb_n_o, "R10 strobe active before mode drop", dstb_n_o, 0);
        mode_i = 3'b000;
        @(negedge clk);
        chk(dstb_n_o && astb_n_o, "R10 strobes released", {dstb_n_o, astb_n_o}, 2'b11);
        repeat (2 * LIMIT) @(negedge clk);
        chk(done_cnt == 0 && !timeout_o, "R10 no done", done_cnt, 0);
        mode_i = 3'b100;
        repeat (4) @(negedge clk);

        // after all that, a normal read still works
        transfer(1'b0, 1'b0, 8'h00, 8'h96, 1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule